// File: doc/BRIEF.md
# Five-Segment Charge Bar Display Controller

This block turns a compensated remaining-charge value and a learned full-charge value into a five-segment bar graph. Each segment stands for one fifth of the full value. The segments are driven as active-low sinks. They are arranged in two banks that take turns, and a common source enable is active only while a bank is being driven. All timing is derived from a one-millisecond tick that the surrounding chip supplies.

A two-bit display mode decides when the bar is visible:
- The display can be forced off.
- It can be shown only while the battery is charging.
- It can be shown for a four-second window that opens each time the mode enters its push-button state.

Two end-of-discharge flags change the picture:
- The early-warning flag makes the lowest segment blink at 4 Hz.
- The final flag blanks the display completely.

Top module: `cap_bar_display`

## Requirements
- R1: The number of lit bar segments is ceil(5 × `avail` / `full`), limited to 5. `avail` = 0 lights none. When `full` = 0, any nonzero `avail` lights all five.
- R2: `seg_n[k-1]` drives segment k, with segment 1 as the lowest fifth. A lit bar of n segments uses segments 1..n. A segment is on when its bit is 0.
- R3: While `edvf` is 1, all of `seg_n` read 1 and `com_en` reads 0.
- R4: While `edv1` is 1 (and `edvf` is 0), segment 1 ignores the bar count. It is on during the first 125 ms of each 250 ms blink period and off for the rest. The blink period is counted in ticks from reset. The other segments still follow R1.
- R5: `mode` 2'b10 or 2'b11 keeps the display dark: `seg_n` all 1 and `com_en` 0.
- R6: `mode` 2'b01 shows the display while `charging` is 1 and keeps it dark otherwise.
- R7: `mode` 2'b00 shows the display for 4000 ticks, counted from the clock in which `mode` changes to 2'b00 from another value. Each new entry into 2'b00 restarts the full 4000 ticks.
- R8: The multiplex phase is the number of ticks since reset, modulo 10. Segments 1, 3 and 5 may be on only in phases 0–2. Segments 2 and 4 may be on only in phases 5–7. No segment is on in phases 3, 4, 8 or 9.
- R9: `com_en` is 1 exactly in phases 0–2 and 5–7 while the display is shown, and 0 otherwise.
- R10: During reset, `seg_n` is all 1 and `com_en` is 0. The phase, blink and window counters restart from zero. The outputs are registered and reflect the inputs and counters one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| avail | input | CAP_W | Compensated remaining charge |
| full | input | CAP_W | Learned full charge |
| charging | input | 1 | Charge activity present |
| edv1 | input | 1 | Early end-of-discharge flag |
| edvf | input | 1 | Final end-of-discharge flag |
| mode | input | 2 | Display mode: 00 timed, 01 on while charging, 1x off |
| seg_n | output | 5 | Active-low segment sinks, bit 0 is segment 1 |
| com_en | output | 1 | Common source enable |

## Verification
The assertions assume the following about the inputs:
- `tick_ms` is a single-cycle pulse.
- `mode`, the flags and `charging` are synchronous and hold for at least one clock.

The assertions then relate a mode or flag value to the registered outputs one clock later. The stimulus meets these assumptions in three ways:
- Inputs change only on falling clock edges.
- Each tick is followed by several idle clocks.
- Random draws are taken for all capacity values, including `full` = 0 and `avail` above `full`, but only over legal flag and mode codes.

// File: rtl/cap_bar_display.sv
module cap_bar_display #(
  parameter int CAP_W           = 16,
  parameter int MUX_PERIOD_MS   = 10,
  parameter int BANK_ON_MS      = 3,
  parameter int BANK_B_OFS      = 5,
  parameter int BLINK_PERIOD_MS = 250,
  parameter int WINDOW_MS       = 4000,
  parameter int NSEG            = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic [CAP_W-1:0] avail,
  input  logic [CAP_W-1:0] full,
  input  logic             charging,
  input  logic             edv1,
  input  logic             edvf,
  input  logic [1:0]       mode,
  output logic [NSEG-1:0]  seg_n,
  output logic             com_en
);

  localparam int MUX_W  = $clog2(MUX_PERIOD_MS);
  localparam int BLK_W  = $clog2(BLINK_PERIOD_MS);
  localparam int WIN_W  = $clog2(WINDOW_MS + 1);
  localparam int PROD_W = CAP_W + $clog2(NSEG + 1);

  localparam logic [MUX_W-1:0] MUX_LAST = MUX_W'(MUX_PERIOD_MS - 1);
  localparam logic [MUX_W-1:0] A_END    = MUX_W'(BANK_ON_MS);
  localparam logic [MUX_W-1:0] B_BEG    = MUX_W'(BANK_B_OFS);
  localparam logic [MUX_W-1:0] B_END    = MUX_W'(BANK_B_OFS + BANK_ON_MS);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLINK_PERIOD_MS - 1);
  localparam logic [BLK_W-1:0] BLK_HALF = BLK_W'(BLINK_PERIOD_MS / 2);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WINDOW_MS);

  localparam logic [1:0] MODE_TIMED  = 2'b00;
  localparam logic [1:0] MODE_CHARGE = 2'b01;

  logic [MUX_W-1:0] mux_cnt;
  logic [BLK_W-1:0] blink_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             timed_q;

  wire timed_now   = (mode == MODE_TIMED);
  wire timed_entry = timed_now && !timed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_cnt   <= '0;
      blink_cnt <= '0;
      win_cnt   <= '0;
      timed_q   <= 1'b0;
    end else begin
      timed_q <= timed_now;
      if (tick_ms) begin
        mux_cnt   <= (mux_cnt == MUX_LAST) ? '0 : mux_cnt + 1'b1;
        blink_cnt <= (blink_cnt == BLK_LAST) ? '0 : blink_cnt + 1'b1;
      end
      if (timed_entry)
        win_cnt <= WIN_LOAD;
      else if (tick_ms && win_cnt != '0)
        win_cnt <= win_cnt - 1'b1;
    end
  end

  wire bank_a   = mux_cnt < A_END;
  wire bank_b   = (mux_cnt >= B_BEG) && (mux_cnt < B_END);
  wire blink_on = blink_cnt < BLK_HALF;

  logic enabled;
  always_comb begin
    case (mode)
      MODE_TIMED:  enabled = (win_cnt != '0);
      MODE_CHARGE: enabled = charging;
      default:     enabled = 1'b0;
    endcase
  end

  wire disp_on = enabled && !edvf;

  wire [PROD_W-1:0] scaled_avail = PROD_W'(avail) * PROD_W'(NSEG);
  logic [NSEG-1:0] seg_on;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    wire [PROD_W-1:0] thresh = PROD_W'(full) * PROD_W'(k);
    wire lit  = scaled_avail > thresh;
    wire bank = (k % 2 == 0) ? bank_a : bank_b;
    if (k == 0) begin : g_low
      assign seg_on[k] = bank && (edv1 ? blink_on : lit);
    end else begin : g_rest
      assign seg_on[k] = bank && lit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_n  <= '1;
      com_en <= 1'b0;
    end else begin
      seg_n  <= ~(seg_on & {NSEG{disp_on}});
      com_en <= disp_on && (bank_a || bank_b);
    end
  end

  a_r3_empty_dark: assert property (@(posedge clk) disable iff (!rst_n)
    edvf |=> (seg_n == '1 && !com_en));

  a_r5_off_mode_dark: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> (seg_n == '1 && !com_en));

  a_r6_no_charge_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CHARGE && !charging) |=> !com_en);

  a_r8_banks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !((~seg_n[0] | ~seg_n[2] | ~seg_n[4]) && (~seg_n[1] | ~seg_n[3])));

  a_r9_sink_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_n != '1) |-> com_en);

endmodule

// File: tb/cap_bar_display_tb_top.sv
module cap_bar_display_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic tick_ms = 0;
  logic [15:0] avail = 0, full = 0;
  logic charging = 0, edv1 = 0, edvf = 0;
  logic [1:0] mode = 2'b10;
  logic [4:0] seg_n;
  logic com_en;

  int checks = 0, fails = 0;
  int tcount = 0, win_rem = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cap_bar_display dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .avail(avail), .full(full),
    .charging(charging), .edv1(edv1), .edvf(edvf), .mode(mode),
    .seg_n(seg_n), .com_en(com_en));

  function automatic int bar_count(input int a, input int f);
    int n;
    if (a == 0) return 0;
    if (f == 0) return 5;
    n = (5 * a + f - 1) / f;
    return (n > 5) ? 5 : n;
  endfunction

  function automatic logic [5:0] expect_out();
    logic shown, ba, bb, blink, on;
    int ph, lit;
    logic [4:0] s;
    ph = tcount % 10;
    ba = ph < 3;
    bb = (ph >= 5) && (ph < 8);
    blink = (tcount % 250) < 125;
    case (mode)
      2'b00: shown = win_rem > 0;
      2'b01: shown = charging;
      default: shown = 0;
    endcase
    shown = shown && !edvf;
    lit = bar_count(avail, full);
    for (int k = 1; k <= 5; k++) begin
      on = (k == 1 && edv1) ? blink : (k <= lit);
      on = on && shown && ((k % 2 == 1) ? ba : bb);
      s[k-1] = ~on;
    end
    return {s, shown && (ba || bb)};
  endfunction

  task automatic check(input string req);
    logic [5:0] e;
    e = expect_out();
    checks++;
    if ({seg_n, com_en} !== e) begin
      fails++;
      $display("FAIL %s t=%0d: seg_n=%b com_en=%b expected seg_n=%b com_en=%b",
               req, tcount, seg_n, com_en, e[5:1], e[0]);
    end
  endtask

  task automatic set_in(input int a, input int f, input logic c, input logic e1,
                        input logic ef, input logic [1:0] m);
    if (m == 2'b00 && mode != 2'b00) win_rem = 4000;
    avail = a[15:0]; full = f[15:0]; charging = c; edv1 = e1; edvf = ef; mode = m;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick_ms = 1;
    @(negedge clk) tick_ms = 0;
    tcount++;
    if (win_rem > 0) win_rem--;
    @(negedge clk);
  endtask

  task automatic ticks_check(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      do_tick();
      check(req);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    check("R10");
    ticks_check(3, "R5");

    // R1 / R2 / R8 / R9: bar counts across a full multiplex period
    set_in(20, 100, 1, 0, 0, 2'b01);  check("R1"); ticks_check(10, "R1");
    set_in(21, 100, 1, 0, 0, 2'b01);  ticks_check(10, "R2");
    set_in(61, 100, 1, 0, 0, 2'b01);  ticks_check(10, "R8");
    set_in(100, 100, 1, 0, 0, 2'b01); ticks_check(10, "R9");
    set_in(150, 100, 1, 0, 0, 2'b01); ticks_check(10, "R1");
    set_in(0, 100, 1, 0, 0, 2'b01);   ticks_check(10, "R1");
    set_in(5, 0, 1, 0, 0, 2'b01);     ticks_check(10, "R1");
    set_in(1, 65535, 1, 0, 0, 2'b01); ticks_check(10, "R1");

    // R6: charge-gated mode
    set_in(80, 100, 0, 0, 0, 2'b01);  ticks_check(10, "R6");
    set_in(80, 100, 1, 0, 0, 2'b01);  ticks_check(10, "R6");

    // R5: both off codes
    set_in(80, 100, 1, 0, 0, 2'b10);  ticks_check(10, "R5");
    set_in(80, 100, 1, 0, 0, 2'b11);  ticks_check(10, "R5");

    // R4: blink across more than one blink period
    set_in(100, 100, 1, 1, 0, 2'b01); ticks_check(260, "R4");
    set_in(0, 100, 1, 1, 0, 2'b01);   ticks_check(20, "R4");

    // R3: final flag blanks everything
    set_in(100, 100, 1, 1, 1, 2'b01); ticks_check(20, "R3");

    // R7: timed window, restart, expiry
    set_in(60, 100, 0, 0, 0, 2'b00);  check("R7");
    ticks_check(3000, "R7");
    set_in(60, 100, 0, 0, 0, 2'b01);  check("R7");
    set_in(60, 100, 0, 0, 0, 2'b00);  check("R7");
    ticks_check(4010, "R7");

    // random mix
    for (int it = 0; it < 250; it++) begin
      int a, f, nt;
      logic [1:0] m;
      f = ($urandom % 8 == 0) ? 0 : ($urandom % 1000);
      a = $urandom % 1200;
      m = $urandom % 4;
      set_in(a, f, $urandom % 2, ($urandom % 4) == 0, ($urandom % 8) == 0, m);
      check("R1");
      nt = 1 + $urandom % 12;
      ticks_check(nt, "R2");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule